// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

The controller reduces many interrupt request pulses to a single request to a CPU. It has two kinds of sources. There are eight nonmaskable traps, numbered 0 to 7. After them come the maskable user sources, with user source n carrying vector number n+8.

Each source keeps a pending flag. A one-cycle pulse on its input sets the flag, and software clears it through a register port. Each user source also has an enable bit and a 3-bit priority. Every cycle the controller picks the single best pending source. It compares that source with the CPU's current 4-bit level. It then presents a registered request together with the vector number, the new CPU level and the address of the vector-table entry.

A select input switches between a primary vector table and an alternate table, which sits 0x100 above the primary one. A nesting-disable input controls which CPU level bits software may change. The controller reports this as a write mask that the CPU applies to its level register.

Top module: `pvic_top`

## Requirements
- R1: On reset, every pending flag, enable bit and priority field is 0. The outputs irq_req, vec_num, new_lvl and vec_addr are also 0.
- R2: A pulse on a source's request input sets that source's flag, and the flag is visible on the read port one cycle later. A register write with data bit 0 = 0 clears the flag. A write with bit 0 = 1 leaves the flag unchanged. If a pulse and a clearing write reach the same source in the same cycle, the pulse wins and the flag ends up set.
- R3: The register index equals the vector number. The register word is 5 bits: bit 0 is the flag, bit 1 is the enable and bits 4:2 are the priority. A write to a user index loads the enable and the priority. A trap index always reads back enable 1 and priority 0, and a write there changes only its flag. An index of 126 or more reads 0, and a write to it is ignored.
- R4: A user source competes at a level equal to its priority, and only while it is flagged and enabled. A user source with priority 0 never causes a request.
- R5: The winner is the pending source with the highest level. Among sources at the same level, the lowest vector number wins.
- R6: A user winner raises a request only if its level is strictly greater than cpu_lvl. As a result, any cpu_lvl of 7 or more blocks every user source.
- R7: Trap n competes at level 15-n. A pending trap raises a request whatever the value of cpu_lvl, and it outranks every user source.
- R8: The outputs are registered. At each clock edge they reflect the flags held before that edge, together with cpu_lvl and alt_sel as sampled at that edge. While irq_req is 1, vec_num is the winner's vector number and new_lvl is its level. While irq_req is 0, all three outputs (vec_num, new_lvl, vec_addr) are 0.
- R9: vec_addr is 0x4 + 2*vec_num. It is 0x100 higher when alt_sel is 1.
- R10: lvl_wr_mask[3] is always 0, since software may never write the top level bit. lvl_wr_mask[2:0] is 3'b111 when nest_dis is 0 and 3'b000 when nest_dis is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trap_pulse | input | 8 | Set pulses for traps 0..7 |
| irq_pulse | input | NUM_USER (118) | Set pulses for user sources |
| reg_wr | input | 1 | Register write strobe |
| reg_idx | input | 7 | Register index (vector number) |
| reg_wdata | input | 5 | Write word {prio, enable, flag} |
| reg_rdata | output | 5 | Read word at reg_idx (combinational) |
| cpu_lvl | input | 4 | Current CPU priority level |
| alt_sel | input | 1 | 1 selects the alternate vector table |
| nest_dis | input | 1 | Nesting disable |
| irq_req | output | 1 | Interrupt request to the CPU |
| vec_num | output | 7 | Winning vector number |
| new_lvl | output | 4 | Level of the winning source |
| vec_addr | output | 24 | Vector table entry address |
| lvl_wr_mask | output | 4 | Writable bits of the CPU level register |

## Verification
Two functions can land on the same source flag in the same cycle: the hardware set pulse and the software clearing write. The bench provokes this in a directed case and also in random traffic, where pulses and writes to random indices overlap often. The result is judged at the read port one cycle later, where the flag must be 1.

In the same traffic, the bench compares every cycle's registered request, vector number, level and address against a reference model. That model searches the bench's own copy of the flag state in ascending order.

// File: rtl/pvic_pkg.sv
package pvic_pkg;
  localparam int TRAP_CNT = 8;
  localparam int LVL_W    = 4;
  localparam int PRIO_W   = 3;
  localparam int WORD_W   = PRIO_W + 2;
  localparam int ADDR_W   = 24;
  localparam int TBL_BASE = 4;
  localparam int ALT_OFS  = 256;
  localparam int TOP_LVL  = (1 << LVL_W) - 1;

  // Fixed level of trap n: lower trap numbers rank higher.
  function automatic logic [LVL_W-1:0] trap_level(input int n);
    return LVL_W'(TOP_LVL - n);
  endfunction

  // Entry address for a vector in the primary or alternate table.
  function automatic logic [ADDR_W-1:0] entry_addr(input logic [15:0] vec, input logic alt);
    int unsigned a;
    a = TBL_BASE + 2 * int'(vec);
    if (alt) a = a + ALT_OFS;
    return ADDR_W'(a);
  endfunction

  // Register word layout: {prio, enable, flag}.
  function automatic logic [WORD_W-1:0] pack_word(input logic [PRIO_W-1:0] prio,
                                                  input logic en, input logic flag);
    return {prio, en, flag};
  endfunction
endpackage

// File: rtl/pvic_src_bank.sv
module pvic_src_bank
  import pvic_pkg::*;
#(
  parameter int NUM_VEC = 126,
  parameter int VEC_W   = 7
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NUM_VEC-1:0]             src_pulse,
  input  logic                           wr_en,
  input  logic [VEC_W-1:0]               idx,
  input  logic [WORD_W-1:0]              wdata,
  output logic [WORD_W-1:0]              rdata,
  output logic [NUM_VEC-1:0][LVL_W-1:0]  pend_lvl
);
  logic [NUM_VEC-1:0][WORD_W-1:0] word;
  logic                           idx_ok;

  assign idx_ok = int'(idx) < NUM_VEC;
  assign rdata  = idx_ok ? word[idx] : '0;

  for (genvar v = 0; v < NUM_VEC; v++) begin : g_src
    logic flag_q;
    logic hit;
    logic clr_req;

    assign hit     = wr_en && (idx == VEC_W'(v));
    assign clr_req = hit && !wdata[0];

    // Hardware set has priority over a software clear in the same cycle.
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            flag_q <= 1'b0;
      else if (src_pulse[v]) flag_q <= 1'b1;
      else if (clr_req)      flag_q <= 1'b0;
    end

    if (v < TRAP_CNT) begin : g_trap
      assign pend_lvl[v] = flag_q ? trap_level(v) : '0;
      assign word[v]     = pack_word('0, 1'b1, flag_q);
    end else begin : g_user
      logic              en_q;
      logic [PRIO_W-1:0] prio_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          en_q   <= 1'b0;
          prio_q <= '0;
        end else if (hit) begin
          en_q   <= wdata[1];
          prio_q <= wdata[WORD_W-1:2];
        end
      end
      assign pend_lvl[v] = (flag_q && en_q) ? LVL_W'(prio_q) : '0;
      assign word[v]     = pack_word(prio_q, en_q, flag_q);
    end

    AST_PULSE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      src_pulse[v] |=> flag_q) else $error("pulse lost"); // R2
    AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_req && !src_pulse[v]) |=> !flag_q) else $error("clear lost"); // R2
  end
endmodule

// File: rtl/pvic_arbiter.sv
module pvic_arbiter
  import pvic_pkg::*;
#(
  parameter int NUM_VEC = 126,
  parameter int VEC_W   = 7
) (
  input  logic [NUM_VEC-1:0][LVL_W-1:0] pend_lvl,
  output logic                          win_valid,
  output logic [VEC_W-1:0]              win_vec,
  output logic [LVL_W-1:0]              win_lvl
);
  // Scan from the highest vector down; ">=" lets a lower number take a tie.
  always_comb begin
    win_valid = 1'b0;
    win_vec   = '0;
    win_lvl   = '0;
    for (int v = NUM_VEC - 1; v >= 0; v--) begin
      if (pend_lvl[v] != '0 && pend_lvl[v] >= win_lvl) begin
        win_valid = 1'b1;
        win_vec   = VEC_W'(v);
        win_lvl   = pend_lvl[v];
      end
    end
  end
endmodule

// File: rtl/pvic_out_stage.sv
module pvic_out_stage
  import pvic_pkg::*;
#(
  parameter int VEC_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              win_valid,
  input  logic [VEC_W-1:0]  win_vec,
  input  logic [LVL_W-1:0]  win_lvl,
  input  logic [LVL_W-1:0]  cpu_lvl,
  input  logic              alt_sel,
  output logic              irq_req,
  output logic [VEC_W-1:0]  vec_num,
  output logic [LVL_W-1:0]  new_lvl,
  output logic [ADDR_W-1:0] vec_addr
);
  logic is_trap_lvl;
  logic grant;

  assign is_trap_lvl = win_lvl[LVL_W-1];
  assign grant       = win_valid && (is_trap_lvl || (win_lvl > cpu_lvl));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_req  <= 1'b0;
      vec_num  <= '0;
      new_lvl  <= '0;
      vec_addr <= '0;
    end else if (grant) begin
      irq_req  <= 1'b1;
      vec_num  <= win_vec;
      new_lvl  <= win_lvl;
      vec_addr <= entry_addr(16'(win_vec), alt_sel);
    end else begin
      irq_req  <= 1'b0;
      vec_num  <= '0;
      new_lvl  <= '0;
      vec_addr <= '0;
    end
  end

  AST_USER_ABOVE_CPU: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && !new_lvl[LVL_W-1]) |-> (new_lvl > $past(cpu_lvl))) else $error("user below cpu"); // R6
  AST_LVL_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (new_lvl != '0)) else $error("zero level granted"); // R4
  AST_TRAP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && int'(vec_num) < TRAP_CNT) |-> new_lvl[LVL_W-1]) else $error("trap level low"); // R7
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_req |-> (vec_num == '0 && new_lvl == '0 && vec_addr == '0)) else $error("idle not zero"); // R8
endmodule

// File: rtl/pvic_top.sv
module pvic_top
  import pvic_pkg::*;
#(
  parameter int NUM_USER = 118,
  parameter int VEC_W    = 7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [7:0]          trap_pulse,
  input  logic [NUM_USER-1:0] irq_pulse,
  input  logic                reg_wr,
  input  logic [VEC_W-1:0]    reg_idx,
  input  logic [4:0]          reg_wdata,
  output logic [4:0]          reg_rdata,
  input  logic [3:0]          cpu_lvl,
  input  logic                alt_sel,
  input  logic                nest_dis,
  output logic                irq_req,
  output logic [VEC_W-1:0]    vec_num,
  output logic [3:0]          new_lvl,
  output logic [23:0]         vec_addr,
  output logic [3:0]          lvl_wr_mask
);
  localparam int NUM_VEC = TRAP_CNT + NUM_USER;

  logic [NUM_VEC-1:0]            src_pulse;
  logic [NUM_VEC-1:0][LVL_W-1:0] pend_lvl;
  logic                          win_valid;
  logic [VEC_W-1:0]              win_vec;
  logic [LVL_W-1:0]              win_lvl;

  assign src_pulse = {irq_pulse, trap_pulse};

  // Top level bit is never software-writable; low bits lock when nesting is off.
  assign lvl_wr_mask = {1'b0, {(LVL_W-1){~nest_dis}}};

  pvic_src_bank #(.NUM_VEC(NUM_VEC), .VEC_W(VEC_W)) i_bank (
    .clk(clk), .rst_n(rst_n), .src_pulse(src_pulse), .wr_en(reg_wr),
    .idx(reg_idx), .wdata(reg_wdata), .rdata(reg_rdata), .pend_lvl(pend_lvl)
  );

  pvic_arbiter #(.NUM_VEC(NUM_VEC), .VEC_W(VEC_W)) i_arb (
    .pend_lvl(pend_lvl), .win_valid(win_valid), .win_vec(win_vec), .win_lvl(win_lvl)
  );

  pvic_out_stage #(.VEC_W(VEC_W)) i_out (
    .clk(clk), .rst_n(rst_n), .win_valid(win_valid), .win_vec(win_vec),
    .win_lvl(win_lvl), .cpu_lvl(cpu_lvl), .alt_sel(alt_sel), .irq_req(irq_req),
    .vec_num(vec_num), .new_lvl(new_lvl), .vec_addr(vec_addr)
  );

  AST_TOP_BIT_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    !lvl_wr_mask[3] && (lvl_wr_mask[2:0] == (nest_dis ? 3'b000 : 3'b111))) else $error("mask"); // R10
  AST_ADDR_TABLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (vec_addr[0] == 1'b0 && vec_addr >= 24'h4 && vec_addr < 24'h200)) else $error("addr range"); // R9
endmodule

// File: tb/test_pvic_top.sv
`timescale 1ns/1ps
module test_pvic_top;
  localparam int NU = 118;
  localparam int NV = NU + 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [7:0]    trap_pulse = '0;
  logic [NU-1:0] irq_pulse = '0;
  logic          reg_wr = 1'b0;
  logic [6:0]    reg_idx = '0;
  logic [4:0]    reg_wdata = '0;
  logic [4:0]    reg_rdata;
  logic [3:0]    cpu_lvl = '0;
  logic          alt_sel = 1'b0;
  logic          nest_dis = 1'b0;
  logic          irq_req;
  logic [6:0]    vec_num;
  logic [3:0]    new_lvl;
  logic [23:0]   vec_addr;
  logic [3:0]    lvl_wr_mask;

  int n_chk = 0;
  int n_bad = 0;
  bit model_on = 0;

  bit     m_flag [NV];
  bit     m_en   [NV];
  int     m_prio [NV];
  bit     e_req;
  int     e_vec, e_lvl, e_addr;

  always #5 clk = ~clk;

  pvic_top i_pvic_top (
    .clk(clk), .rst_n(rst_n), .trap_pulse(trap_pulse), .irq_pulse(irq_pulse),
    .reg_wr(reg_wr), .reg_idx(reg_idx), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cpu_lvl(cpu_lvl), .alt_sel(alt_sel), .nest_dis(nest_dis), .irq_req(irq_req),
    .vec_num(vec_num), .new_lvl(new_lvl), .vec_addr(vec_addr), .lvl_wr_mask(lvl_wr_mask)
  );

  function automatic int lvl_of(int v);
    if (!m_flag[v]) return 0;
    if (v < 8) return 15 - v;
    return m_en[v] ? m_prio[v] : 0;
  endfunction

  function automatic int word_of(int idx);
    if (idx >= NV) return 0;
    if (idx < 8) return 2 + int'(m_flag[idx]);
    return m_prio[idx] * 4 + int'(m_en[idx]) * 2 + int'(m_flag[idx]);
  endfunction

  task automatic check(string req, int act, int exp, string what);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // Reference model: ascending search, strictly greater replaces.
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int v = 0; v < NV; v++) begin m_flag[v] = 0; m_en[v] = 0; m_prio[v] = 0; end
      e_req = 0; e_vec = 0; e_lvl = 0; e_addr = 0;
    end else begin
      int bl, bv;
      bl = 0; bv = 0;
      for (int v = 0; v < NV; v++) if (lvl_of(v) > bl) begin bl = lvl_of(v); bv = v; end
      e_req  = (bl != 0) && (bl >= 8 || bl > int'(cpu_lvl));
      e_vec  = e_req ? bv : 0;
      e_lvl  = e_req ? bl : 0;
      e_addr = e_req ? (4 + 2 * bv + (alt_sel ? 256 : 0)) : 0;
      for (int v = 0; v < NV; v++) begin
        bit p;
        p = (v < 8) ? trap_pulse[v] : irq_pulse[v-8];
        if (reg_wr && int'(reg_idx) == v) begin
          if (v >= 8) begin m_en[v] = reg_wdata[1]; m_prio[v] = int'(reg_wdata[4:2]); end
          if (!reg_wdata[0]) m_flag[v] = 0;
        end
        if (p) m_flag[v] = 1;
      end
    end
  end

  always @(negedge clk) begin
    if (model_on) begin
      check("R8", int'(irq_req), int'(e_req), "irq_req");
      check("R5", int'(vec_num), e_vec, "vec_num");
      check("R7", int'(new_lvl), e_lvl, "new_lvl");
      check("R9", int'(vec_addr), e_addr, "vec_addr");
      check("R3", int'(reg_rdata), word_of(int'(reg_idx)), "reg_rdata");
      check("R10", int'(lvl_wr_mask), nest_dis ? 0 : 7, "lvl_wr_mask");
    end
  end

  task automatic step();
    @(posedge clk); #3;
  endtask

  task automatic wr(int idx, int d);
    reg_wr = 1; reg_idx = 7'(idx); reg_wdata = 5'(d);
    step();
    reg_wr = 0;
  endtask

  task automatic upulse(int n);
    irq_pulse[n] = 1'b1; step(); irq_pulse[n] = 1'b0;
  endtask

  task automatic clear_all();
    for (int v = 0; v < NV; v++) wr(v, 0);
    step();
  endtask

  initial begin
    #(200000 * 10);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #3;
    // R1: reset state at the ports
    check("R1", int'(irq_req), 0, "irq_req in reset");
    check("R1", int'(vec_addr), 0, "vec_addr in reset");
    reg_idx = 7'd20;
    #1 check("R1", int'(reg_rdata), 0, "word in reset");
    rst_n = 1'b1;
    step();
    model_on = 1;

    // R10: level write mask
    nest_dis = 1; #1 check("R10", int'(lvl_wr_mask), 0, "mask nest off");
    nest_dis = 0; #1 check("R10", int'(lvl_wr_mask), 7, "mask nest on");

    // R3: word layout on user and trap indices, out-of-range index
    wr(20, 5'b11010);
    reg_idx = 7'd20; #1 check("R3", int'(reg_rdata), 5'b11010, "user word");
    wr(2, 5'b11110);
    reg_idx = 7'd2; #1 check("R3", int'(reg_rdata), 5'b00010, "trap word fixed");
    wr(127, 5'b11110);
    reg_idx = 7'd127; #1 check("R3", int'(reg_rdata), 0, "out of range");

    // R2: set, write-1 keeps, write-0 clears, pulse beats clear
    upulse(12);
    reg_idx = 7'd20; #1 check("R2", int'(reg_rdata), 5'b11011, "pulse sets");
    wr(20, 5'b11011);
    reg_idx = 7'd20; #1 check("R2", int'(reg_rdata), 5'b11011, "write 1 keeps");
    wr(20, 5'b11010);
    reg_idx = 7'd20; #1 check("R2", int'(reg_rdata), 5'b11010, "write 0 clears");
    irq_pulse[12] = 1'b1; wr(20, 5'b11010); irq_pulse[12] = 1'b0;
    reg_idx = 7'd20; #1 check("R2", int'(reg_rdata), 5'b11011, "set wins collision");
    clear_all();

    // R5: tie at level 5 between vectors 11 and 18
    cpu_lvl = 0;
    wr(11, 5'b10110); wr(18, 5'b10110);
    irq_pulse[3] = 1'b1; irq_pulse[10] = 1'b1; step();
    irq_pulse[3] = 1'b0; irq_pulse[10] = 1'b0; step();
    check("R5", int'(vec_num), 11, "tie lowest wins");
    check("R9", int'(vec_addr), 24'h1A, "primary address");
    alt_sel = 1; step();
    check("R9", int'(vec_addr), 24'h11A, "alternate address");
    alt_sel = 0;
    // R5: higher level beats lower vector number
    wr(58, 5'b11010); upulse(50); step();
    check("R5", int'(vec_num), 58, "higher level wins");
    check("R8", int'(new_lvl), 6, "new level");
    // R6: cpu level gating
    cpu_lvl = 6; step(); check("R6", int'(irq_req), 0, "equal level blocked");
    cpu_lvl = 5; step(); check("R6", int'(irq_req), 1, "above level passes");
    cpu_lvl = 7; step(); check("R6", int'(irq_req), 0, "level 7 blocks");
    cpu_lvl = 8; step(); check("R6", int'(irq_req), 0, "level 8 blocks");
    // R7: trap passes at level 15; lower trap number ranks higher
    cpu_lvl = 15;
    trap_pulse[3] = 1'b1; step(); trap_pulse[3] = 1'b0; step();
    check("R7", int'(vec_num), 3, "trap unmasked");
    check("R7", int'(new_lvl), 12, "trap level");
    trap_pulse[1] = 1'b1; step(); trap_pulse[1] = 1'b0; step();
    check("R7", int'(vec_num), 1, "lower trap wins");
    clear_all();
    // R4: priority 0 or disabled never requests
    cpu_lvl = 0;
    wr(68, 5'b00010); wr(70, 5'b11100);
    upulse(60); upulse(62); step();
    check("R4", int'(irq_req), 0, "prio 0 or disabled silent");
    clear_all();

    // Random traffic with a fixed seed
    void'($urandom(32'd20240611));
    for (int c = 0; c < 6000; c++) begin
      for (int n = 0; n < NU; n++) irq_pulse[n] = ($urandom_range(0, 63) == 0);
      for (int n = 0; n < 8; n++) trap_pulse[n] = ($urandom_range(0, 255) == 0);
      reg_wr    = ($urandom_range(0, 1) == 1);
      reg_idx   = 7'($urandom_range(0, 127));
      reg_wdata = 5'($urandom_range(0, 31));
      cpu_lvl   = (c < 3000) ? 4'($urandom_range(0, 7)) : 4'($urandom_range(0, 15));
      alt_sel   = 1'($urandom_range(0, 1));
      nest_dis  = 1'($urandom_range(0, 1));
      step();
    end
    irq_pulse = '0; trap_pulse = '0; reg_wr = 0;
    step();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule